// File: doc/BRIEF.md
# Thread Interrupt Priority Context

This block keeps the interrupt priority state of one hardware thread. The state is split into four rings: user (index 0), OS (index 1), hypervisor pool (index 2) and physical (index 3). Each ring takes 16 bytes of a 64-byte register window. Each ring holds an 8-bit pending buffer and a current processor priority. It also exposes a derived pending priority, which is the most favoured priority still waiting.

Notifications arrive with a ring index and a priority. Priority 0 is the most favoured and 7 is the least favoured active level. A notification sets one bit of the chosen ring's pending buffer. A ring signals an exception when its pending priority is numerically below its current priority. The pool and physical rings drive the hypervisor exception line, and the OS ring drives the OS exception line.

A single-beat register port lets the thread read and write the context. It can also acknowledge the best pending interrupt. A page-select input sets the privilege of each access, and page 0 is the most privileged.

The port has a two-state machine. `PORT_IDLE` means no read result is being presented. `PORT_RESP` means a read result is valid in this cycle. The machine takes IDLE→RESP and RESP→RESP on a read request. It takes RESP→IDLE and IDLE→IDLE on a write or on no request.

Top module: `tctx_ctx`

## Requirements
- R1: After reset, every pending buffer is 0x00 and every current priority is 0x00. Both exception outputs are low and `acc_rvalid` is low.
- R2: A notification with priority p ≤ 7 sets bit (7 − p) of the addressed ring's pending buffer. A notification with p > 7 changes nothing.
- R3: Reading offset 0x2 of a ring returns its pending priority. This is the number of leading zeros of the 8-bit pending buffer, counted from bit 7, or 0xFF when the buffer is zero.
- R4: A ring raises its exception when its pending priority is less than its current priority. `hv_irq` is the OR of rings 2 and 3, `os_irq` follows ring 1, and ring 0 drives no output.
- R5: A read of offset 0x3 (acknowledge) returns the pending priority. When that value is not 0xFF, the access also clears the matching pending bit and loads the current priority with the same value. When nothing is pending, the read returns 0xFF and changes no state.
- R6: Offset 0x0 (pending buffer) and offset 0x1 (current priority) are readable and writable. A notification in the same cycle as a pending-buffer write is ORed over the written value.
- R7: Page p reaches only rings whose index is at most 3 − p. An access outside that range writes nothing, acknowledges nothing and reads 0x00.
- R8: Read data and `acc_rvalid` appear on the cycle after the request, and `acc_rdata` holds between reads. Offsets 0x4–0xF read 0x00, and writes to offsets 0x2–0xF are ignored.
- R9: When an acknowledge and a notification hit the same ring in the same cycle, the notified bit is set after the acknowledge clears its bit. The notified bit survives even when the two bits are the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ntf_valid | input | 1 | Notification strobe |
| ntf_ring | input | 2 | Ring index of the notification |
| ntf_prio | input | 8 | Priority of the notification |
| acc_req | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_page | input | 2 | Privilege page of the access (0 = most privileged) |
| acc_addr | input | 6 | Byte address: [5:4] ring, [3:0] offset |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid with acc_rvalid |
| acc_rvalid | output | 1 | Read result valid |
| hv_irq | output | 1 | Hypervisor-level exception |
| os_irq | output | 1 | OS-level exception |

## Verification
The hardest case to reach is an acknowledge that meets a notification on the same ring in the same cycle, especially when both target the same pending bit. The case is harder still when a less privileged page is also probing rings it cannot see. The stimulus drives this collision directly and then runs a long pseudo-random stream. That stream mixes notifications, acknowledges, writes and reads across all pages, and it keeps ring and priority ranges narrow so collisions recur. A behavioural model in the bench is compared with the outputs on every cycle.

// File: rtl/tctx_pkg.sv
package tctx_pkg;
    localparam int PRIO_LEVELS = 8;

    typedef logic [7:0] byte_t;

    localparam byte_t PRIO_NONE = 8'hFF;

    localparam logic [3:0] OFF_PEND = 4'h0;
    localparam logic [3:0] OFF_CPPR = 4'h1;
    localparam logic [3:0] OFF_PIPR = 4'h2;
    localparam logic [3:0] OFF_ACK  = 4'h3;

    typedef enum logic {
        PORT_IDLE,
        PORT_RESP
    } port_state_e;

    // Most favoured pending level: highest set bit wins.
    function automatic byte_t lead_zero_prio(input byte_t vec);
        byte_t res;
        res = PRIO_NONE;
        for (int i = 0; i < PRIO_LEVELS; i++) begin
            if (vec[i]) res = byte_t'(PRIO_LEVELS - 1 - i);
        end
        return res;
    endfunction

    // One-hot pending bit of a priority, zero when inactive.
    function automatic byte_t prio_bit(input byte_t prio);
        byte_t res;
        res = '0;
        if (int'(prio) < PRIO_LEVELS) res[PRIO_LEVELS - 1 - int'(prio)] = 1'b1;
        return res;
    endfunction
endpackage

// File: rtl/tctx_ring.sv
module tctx_ring
    import tctx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ntf_hit,
    input  byte_t ntf_prio,
    input  logic  wr_pend,
    input  logic  wr_cppr,
    input  byte_t wdata,
    input  logic  ack,
    output byte_t pend_o,
    output byte_t cppr_o,
    output byte_t pipr_o,
    output logic  exc_o
);
    byte_t pend_q, cppr_q, pend_d, cppr_d, pipr;

    always_comb pipr = lead_zero_prio(pend_q);

    always_comb begin
        pend_d = pend_q;
        cppr_d = cppr_q;
        if (wr_pend) pend_d = wdata;
        if (wr_cppr) cppr_d = wdata;
        if (ack && pipr != PRIO_NONE) begin
            pend_d = pend_d & ~prio_bit(pipr);
            cppr_d = pipr;
        end
        if (ntf_hit) pend_d = pend_d | prio_bit(ntf_prio);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            cppr_q <= '0;
        end else begin
            pend_q <= pend_d;
            cppr_q <= cppr_d;
        end
    end

    always_comb begin
        pend_o = pend_q;
        cppr_o = cppr_q;
        pipr_o = pipr;
        exc_o  = pipr < cppr_q;
    end

    assert_notify_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_hit && int'(ntf_prio) < PRIO_LEVELS) |=> ((pend_q & $past(prio_bit(ntf_prio))) != 8'h00));

    assert_pipr_top_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pipr != PRIO_NONE) |-> ((pend_q >> (PRIO_LEVELS - 1 - int'(pipr))) == 8'h01));

    assert_exc_needs_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> (pend_q != 8'h00));

    assert_ack_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pipr != PRIO_NONE && !ntf_hit) |=>
            (cppr_q == $past(pipr)) && ((pend_q & $past(prio_bit(pipr))) == 8'h00));
endmodule

// File: rtl/tctx_access.sv
module tctx_access
    import tctx_pkg::*;
#(
    parameter int NUM_RINGS  = 4,
    parameter int RING_BYTES = 16,
    localparam int RING_AW   = $clog2(NUM_RINGS),
    localparam int OFF_AW    = $clog2(RING_BYTES),
    localparam int ADDR_W    = RING_AW + OFF_AW
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_req,
    input  logic                 acc_write,
    input  logic [RING_AW-1:0]   acc_page,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  byte_t                pend_i [NUM_RINGS],
    input  byte_t                cppr_i [NUM_RINGS],
    input  byte_t                pipr_i [NUM_RINGS],
    output logic [NUM_RINGS-1:0] wr_pend,
    output logic [NUM_RINGS-1:0] wr_cppr,
    output logic [NUM_RINGS-1:0] ack,
    output byte_t                rdata,
    output logic                 rvalid
);
    logic [RING_AW-1:0] ring_sel;
    logic [OFF_AW-1:0]  off;
    logic               allowed, rd;
    byte_t              rd_val, rdata_q;
    port_state_e        state_q, state_d;

    always_comb begin
        ring_sel = acc_addr[ADDR_W-1:OFF_AW];
        off      = acc_addr[OFF_AW-1:0];
        allowed  = (int'(ring_sel) + int'(acc_page)) <= (NUM_RINGS - 1);
        rd       = acc_req && !acc_write;
    end

    always_comb begin
        for (int i = 0; i < NUM_RINGS; i++) begin
            wr_pend[i] = acc_req && acc_write && allowed && ring_sel == RING_AW'(i) && off == OFF_AW'(OFF_PEND);
            wr_cppr[i] = acc_req && acc_write && allowed && ring_sel == RING_AW'(i) && off == OFF_AW'(OFF_CPPR);
            ack[i]     = rd && allowed && ring_sel == RING_AW'(i) && off == OFF_AW'(OFF_ACK);
        end
    end

    always_comb begin
        rd_val = '0;
        if (allowed) begin
            if (off == OFF_AW'(OFF_PEND))      rd_val = pend_i[ring_sel];
            else if (off == OFF_AW'(OFF_CPPR)) rd_val = cppr_i[ring_sel];
            else if (off == OFF_AW'(OFF_PIPR) || off == OFF_AW'(OFF_ACK)) rd_val = pipr_i[ring_sel];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: state_d = rd ? PORT_RESP : PORT_IDLE;
            PORT_RESP: state_d = rd ? PORT_RESP : PORT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PORT_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd) rdata_q <= rd_val;
        end
    end

    always_comb begin
        rvalid = (state_q == PORT_RESP);
        rdata  = rdata_q;
    end

    assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);

    assert_denied_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !allowed) |=> (rdata == 8'h00));
endmodule

// File: rtl/tctx_ctx.sv
module tctx_ctx
    import tctx_pkg::*;
#(
    parameter int NUM_RINGS  = 4,
    parameter int RING_BYTES = 16,
    localparam int RING_AW   = $clog2(NUM_RINGS),
    localparam int OFF_AW    = $clog2(RING_BYTES),
    localparam int ADDR_W    = RING_AW + OFF_AW
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ntf_valid,
    input  logic [RING_AW-1:0] ntf_ring,
    input  logic [7:0]         ntf_prio,
    input  logic               acc_req,
    input  logic               acc_write,
    input  logic [RING_AW-1:0] acc_page,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [7:0]         acc_wdata,
    output logic [7:0]         acc_rdata,
    output logic               acc_rvalid,
    output logic               hv_irq,
    output logic               os_irq
);
    byte_t                pend_a [NUM_RINGS];
    byte_t                cppr_a [NUM_RINGS];
    byte_t                pipr_a [NUM_RINGS];
    logic [NUM_RINGS-1:0] exc_a, wr_pend, wr_cppr, ack;

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        tctx_ring u_ring (
            .clk      (clk),
            .rst_n    (rst_n),
            .ntf_hit  (ntf_valid && ntf_ring == RING_AW'(g)),
            .ntf_prio (ntf_prio),
            .wr_pend  (wr_pend[g]),
            .wr_cppr  (wr_cppr[g]),
            .wdata    (acc_wdata),
            .ack      (ack[g]),
            .pend_o   (pend_a[g]),
            .cppr_o   (cppr_a[g]),
            .pipr_o   (pipr_a[g]),
            .exc_o    (exc_a[g])
        );
    end

    tctx_access #(
        .NUM_RINGS  (NUM_RINGS),
        .RING_BYTES (RING_BYTES)
    ) u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_req   (acc_req),
        .acc_write (acc_write),
        .acc_page  (acc_page),
        .acc_addr  (acc_addr),
        .pend_i    (pend_a),
        .cppr_i    (cppr_a),
        .pipr_i    (pipr_a),
        .wr_pend   (wr_pend),
        .wr_cppr   (wr_cppr),
        .ack       (ack),
        .rdata     (acc_rdata),
        .rvalid    (acc_rvalid)
    );

    // Physical and pool rings share the hypervisor line; OS ring has its own.
    always_comb begin
        hv_irq = exc_a[NUM_RINGS-1] | exc_a[NUM_RINGS-2];
        os_irq = exc_a[1];
    end

    assert_user_ring_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (os_irq || hv_irq) |-> (exc_a[NUM_RINGS-1:1] != '0));
endmodule

// File: tb/tctx_ctx_tb_top.sv
`timescale 1ns/1ps
module tctx_ctx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ntf_valid = 1'b0;
    logic [1:0] ntf_ring = '0;
    logic [7:0] ntf_prio = '0;
    logic       acc_req = 1'b0;
    logic       acc_write = 1'b0;
    logic [1:0] acc_page = '0;
    logic [5:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       acc_rvalid, hv_irq, os_irq;

    always #2.5 clk = ~clk;

    tctx_ctx dut_i (
        .clk(clk), .rst_n(rst_n),
        .ntf_valid(ntf_valid), .ntf_ring(ntf_ring), .ntf_prio(ntf_prio),
        .acc_req(acc_req), .acc_write(acc_write), .acc_page(acc_page),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid),
        .hv_irq(hv_irq), .os_irq(os_irq)
    );

    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    logic [7:0] m_pend [4];
    logic [7:0] m_cppr [4];
    logic [7:0] e_rdata = 8'h00;
    logic       e_rvalid = 1'b0, e_hv = 1'b0, e_os = 1'b0;
    string      prev_tag = "R1";
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [7:0] m_best(input logic [7:0] b);
        for (int k = 0; k < 8; k++) if (b[7-k]) return 8'(k);
        return 8'hFF;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_outputs();
        check({prev_tag, "/R4 hv_irq"}, {7'd0, hv_irq}, {7'd0, e_hv});
        check({prev_tag, "/R4 os_irq"}, {7'd0, os_irq}, {7'd0, e_os});
        check({prev_tag, "/R8 rvalid"}, {7'd0, acc_rvalid}, {7'd0, e_rvalid});
        check({prev_tag, " rdata"}, acc_rdata, e_rdata);
    endtask

    task automatic step(input logic nv, input logic [1:0] nr, input logic [7:0] np,
                        input logic rq, input logic wr, input logic [1:0] pg,
                        input logic [5:0] ad, input logic [7:0] wd, input string tag);
        int r, off;
        bit ok, rd;
        logic [7:0] best;
        @(negedge clk);
        compare_outputs();
        ntf_valid = nv; ntf_ring = nr; ntf_prio = np;
        acc_req = rq; acc_write = wr; acc_page = pg; acc_addr = ad; acc_wdata = wd;
        r = int'(ad[5:4]); off = int'(ad[3:0]);
        ok = (r + int'(pg)) <= 3;
        rd = rq && !wr;
        best = m_best(m_pend[r]);
        e_rvalid = rd;
        if (rd) begin
            e_rdata = 8'h00;
            if (ok) begin
                if (off == 0) e_rdata = m_pend[r];
                else if (off == 1) e_rdata = m_cppr[r];
                else if (off == 2 || off == 3) e_rdata = best;
            end
        end
        if (rq && wr && ok && off == 0) m_pend[r] = wd;
        if (rq && wr && ok && off == 1) m_cppr[r] = wd;
        if (rd && ok && off == 3 && best != 8'hFF) begin
            m_pend[r][7 - int'(best)] = 1'b0;
            m_cppr[r] = best;
        end
        if (nv && np <= 8'd7) m_pend[nr][7 - int'(np)] = 1'b1;
        e_hv = (m_best(m_pend[2]) < m_cppr[2]) || (m_best(m_pend[3]) < m_cppr[3]);
        e_os = m_best(m_pend[1]) < m_cppr[1];
        prev_tag = tag;
    endtask

    task automatic idle(input string tag);
        step(1'b0, 2'd0, 8'd0, 1'b0, 1'b0, 2'd0, 6'd0, 8'd0, tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_pend[i] = 8'h00; m_cppr[i] = 8'h00; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset contents of rings 3 and 1
        step(0, 0, 0, 1, 0, 0, 6'h30, 0, "R1");
        step(0, 0, 0, 1, 0, 0, 6'h11, 0, "R1");
        // R6: OS page writes OS ring current priority
        step(0, 0, 0, 1, 1, 2, 6'h11, 8'h05, "R6");
        step(0, 0, 0, 1, 0, 2, 6'h11, 0, "R6");
        // R2 / R4
        step(1, 1, 8'd6, 0, 0, 0, 0, 0, "R2");
        step(1, 1, 8'd3, 0, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 1, 0, 0, 6'h12, 0, "R3");
        step(1, 1, 8'd9, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 1, 0, 0, 6'h10, 0, "R2");
        // R5: acknowledge
        step(0, 0, 0, 1, 0, 2, 6'h13, 0, "R5");
        step(0, 0, 0, 1, 0, 0, 6'h11, 0, "R5");
        // R9: acknowledge meets notification on the same ring
        step(1, 1, 8'd6, 1, 0, 2, 6'h13, 0, "R9");
        step(0, 0, 0, 1, 0, 0, 6'h10, 0, "R9");
        step(1, 1, 8'd3, 1, 0, 1, 6'h13, 0, "R9");
        step(0, 0, 0, 1, 0, 0, 6'h10, 0, "R9");
        // R7: user page cannot reach the OS ring
        step(0, 0, 0, 1, 1, 3, 6'h11, 8'hFF, "R7");
        step(0, 0, 0, 1, 0, 3, 6'h11, 0, "R7");
        step(0, 0, 0, 1, 0, 3, 6'h13, 0, "R7");
        step(0, 0, 0, 1, 0, 0, 6'h11, 0, "R7");
        step(0, 0, 0, 1, 1, 2, 6'h21, 8'hFF, "R7");
        // R4: physical and pool rings on hv_irq, user ring silent
        step(0, 0, 0, 1, 1, 0, 6'h31, 8'hFF, "R4");
        step(1, 3, 8'd0, 0, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 1, 0, 0, 6'h33, 0, "R4");
        step(0, 0, 0, 1, 1, 1, 6'h21, 8'hFF, "R4");
        step(1, 2, 8'd7, 0, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 1, 1, 3, 6'h01, 8'hFF, "R4");
        step(1, 0, 8'd2, 0, 0, 0, 0, 0, "R4");
        // R8: unmapped offsets and read-only offsets
        step(0, 0, 0, 1, 0, 0, 6'h07, 0, "R8");
        step(0, 0, 0, 1, 1, 0, 6'h02, 8'h00, "R8");
        step(0, 0, 0, 1, 0, 0, 6'h02, 0, "R8");
        idle("R8");
        // R5: acknowledge on an empty ring
        step(0, 0, 0, 1, 0, 0, 6'h33, 0, "R5");
        step(0, 0, 0, 1, 0, 0, 6'h33, 0, "R5");
        step(0, 0, 0, 1, 0, 0, 6'h31, 0, "R5");
        // R6: write pending buffer with a notification in the same cycle
        step(1, 3, 8'd1, 1, 1, 0, 6'h30, 8'h01, "R6");
        step(0, 0, 0, 1, 0, 0, 6'h30, 0, "R6");
        step(0, 0, 0, 1, 0, 0, 6'h32, 0, "R3");
        // Mixed stream
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] a, b;
            seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; b = seed;
            step(a[0], a[2:1], (a[3] ? {4'd0, a[7:4] & 4'h7} : {4'd0, a[7:4]}),
                 a[8] | a[9], a[10] & a[11], b[1:0],
                 {b[3:2], 2'b00, b[5:4] & {~b[6], 1'b1}}, b[15:8],
                 (a[10] & a[11]) ? "R6" : (b[5:4] == 2'd3 ? "R5" : "R3"));
        end
        idle("R8");
        @(negedge clk);
        compare_outputs();
        done = 1'b1;
        finish_run();
    end
endmodule